// File: doc/BRIEF.md
# System Control Register File

This block is a memory-mapped control and status register file on a simple 32-bit register bus. The bus carries a byte address, a write strobe with write data, and a read strobe with read data. The block decodes a 4 KiB window. Only the lower 512 words of that window have storage behind them, and the word index is the byte offset shifted right by two.

Two behaviours set the block apart from plain storage. First, one command offset above the backed region acts as a trigger. A full-word write of 1 or 2 there produces a one-cycle system reset request, and a write of 3 produces a one-cycle shutdown request. Nothing is stored at that offset. Second, three identity offsets return their stored word with two status bits forced high, and the stored word itself stays unchanged.

Accesses beyond the backed region have defined results: writes are dropped and reads return zero. Any such access, other than the command write, raises a one-cycle access-error flag for debug.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, word 0x40 (byte 0x100) holds 0x05F20121, word 0x41 holds 0x00000002, word 0x42 holds 0x05F30121 and word 0x43 holds 0x05F40121. Every other word holds zero. `rd_data`, `rst_req`, `shdn_req` and `acc_err` are all low.
- R2: A write of 0x00000001 or 0x00000002 to byte offset 0xF00 sets `rst_req` high for exactly the cycle after the write.
- R3: A write of 0x00000003 to byte offset 0xF00 sets `shdn_req` high for exactly the cycle after the write.
- R4: A write of any other value to byte offset 0xF00 raises neither request. No command write raises `acc_err` or changes any stored word.
- R5: An in-range word (byte offsets 0x000 to 0x7FC) is plain 32-bit storage with full-word writes. Read data appears on `rd_data` in the cycle after the read strobe. A read and a write to the same offset in the same cycle return the old value.
- R6: A read at exact byte offset 0x100, 0x108 or 0x10C returns the stored word ORed with 0x30000000, and the stored word is not modified. Offset 0x104 and unaligned offsets are not forced.
- R7: A write at word index 0x200 or above is dropped, including to the low word it would alias after truncation. A read there returns zero.
- R8: Any out-of-range access other than a write to 0xF00 sets `acc_err` high for the cycle after the access. An in-range access leaves it low.
- R9: `rd_data` holds its last value in every cycle that follows a cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Byte offset within the window |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| rst_req | output | 1 | One-cycle system reset request |
| shdn_req | output | 1 | One-cycle shutdown request |
| acc_err | output | 1 | One-cycle out-of-range access flag |

## Verification
A corrupted storage word stays hidden until that word is read back, and then it shows on `rd_data` one cycle after the strobe. For that reason every default word and every written pattern is read back. A bad range or index decode shows as aliasing: a dropped high write overwrites a low word, and that shows on the next read of the low word. A wrong command decode shows on the request pulses in the cycle right after the write. A stuck pulse shows one cycle later.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam logic [31:0] FORCE_MASK = 32'h3000_0000;
  localparam int unsigned CMD_OFFSET = 32'h0000_0F00;
  localparam int unsigned N_FORCED   = 3;

  typedef enum logic [1:0] {
    CMD_NONE     = 2'd0,
    CMD_RESET    = 2'd1,
    CMD_SHUTDOWN = 2'd2
  } sys_cmd_e;

  function automatic int unsigned forced_offset(input int unsigned k);
    case (k)
      0:       forced_offset = 32'h100;
      1:       forced_offset = 32'h108;
      default: forced_offset = 32'h10C;
    endcase
  endfunction

  function automatic logic [31:0] word_default(input int unsigned idx);
    case (idx)
      32'h40:  word_default = 32'h05F2_0121;
      32'h41:  word_default = 32'h0000_0002;
      32'h42:  word_default = 32'h05F3_0121;
      32'h43:  word_default = 32'h05F4_0121;
      default: word_default = 32'h0;
    endcase
  endfunction

  function automatic sys_cmd_e decode_cmd(input logic [31:0] v);
    if (v == 32'd1 || v == 32'd2) decode_cmd = CMD_RESET;
    else if (v == 32'd3)          decode_cmd = CMD_SHUTDOWN;
    else                          decode_cmd = CMD_NONE;
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned WORDS  = 512,
  localparam int unsigned IDX_W  = ADDR_W - 2,
  localparam int unsigned SIDX_W = $clog2(WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SIDX_W-1:0] word_idx,
  output logic              in_range,
  output logic              cmd_hit,
  output logic              force_hit
);
  import sysctl_pkg::*;

  logic [IDX_W-1:0] full_idx;

  assign full_idx = addr[ADDR_W-1:2];
  assign word_idx = full_idx[SIDX_W-1:0];
  assign in_range = ({1'b0, full_idx} < (IDX_W+1)'(WORDS));
  assign cmd_hit  = (addr == ADDR_W'(CMD_OFFSET));

  always_comb begin
    force_hit = 1'b0;
    for (int unsigned k = 0; k < N_FORCED; k++) begin
      if (addr == ADDR_W'(forced_offset(k))) force_hit = 1'b1;
    end
  end

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 512,
  localparam int unsigned SIDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SIDX_W-1:0] idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_word
);
  import sysctl_pkg::*;

  logic [DATA_W-1:0] mem [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic              we;
    logic [DATA_W-1:0] nxt;
    assign we  = wr_en && (idx == SIDX_W'(g));
    assign nxt = wr_data;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem[g] <= DATA_W'(word_default(g));
      else if (we) mem[g] <= nxt;
    end
  end

  assign rd_word = mem[idx];

endmodule

// File: rtl/sysctl_rdport.sv
module sysctl_rdport #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              in_range,
  input  logic              force_hit,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] rd_data
);
  import sysctl_pkg::*;

  logic [DATA_W-1:0] rd_nxt;

  always_comb begin
    if (!in_range)      rd_nxt = '0;
    else if (force_hit) rd_nxt = word | DATA_W'(FORCE_MASK);
    else                rd_nxt = word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_nxt;
  end

endmodule

// File: rtl/sysctl_events.sv
module sysctl_events #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              in_range,
  input  logic              cmd_hit,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rst_req,
  output logic              shdn_req,
  output logic              acc_err
);
  import sysctl_pkg::*;

  sys_cmd_e cmd;
  logic     rst_nxt, shdn_nxt, err_nxt, cmd_wr;

  always_comb begin
    cmd_wr   = wr_en && cmd_hit;
    cmd      = cmd_wr ? decode_cmd(32'(wr_data)) : CMD_NONE;
    rst_nxt  = (cmd == CMD_RESET);
    shdn_nxt = (cmd == CMD_SHUTDOWN);
    err_nxt  = !in_range && ((wr_en && !cmd_hit) || rd_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req  <= 1'b0;
      shdn_req <= 1'b0;
      acc_err  <= 1'b0;
    end else begin
      rst_req  <= rst_nxt;
      shdn_req <= shdn_nxt;
      acc_err  <= err_nxt;
    end
  end

  assert_req_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && shdn_req));

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rst_req,
  output logic              shdn_req,
  output logic              acc_err
);
  import sysctl_pkg::*;

  localparam int unsigned SIDX_W = $clog2(WORDS);

  logic [SIDX_W-1:0] word_idx;
  logic              in_range, cmd_hit, force_hit, store_we;
  logic [DATA_W-1:0] word;

  sysctl_decode #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_decode (
    .addr(addr), .word_idx(word_idx), .in_range(in_range),
    .cmd_hit(cmd_hit), .force_hit(force_hit)
  );

  assign store_we = wr_en && in_range;

  sysctl_store #(.DATA_W(DATA_W), .WORDS(WORDS)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(store_we), .idx(word_idx),
    .wr_data(wr_data), .rd_word(word)
  );

  sysctl_rdport #(.DATA_W(DATA_W)) u_rdport (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .in_range(in_range),
    .force_hit(force_hit), .word(word), .rd_data(rd_data)
  );

  sysctl_events #(.DATA_W(DATA_W)) u_events (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .in_range(in_range), .cmd_hit(cmd_hit), .wr_data(wr_data),
    .rst_req(rst_req), .shdn_req(shdn_req), .acc_err(acc_err)
  );

  assert_rst_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(wr_en) && $past(addr) == ADDR_W'(CMD_OFFSET) &&
                 ($past(wr_data) == DATA_W'(1) || $past(wr_data) == DATA_W'(2))));

  assert_shdn_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_req |-> ($past(wr_en) && $past(addr) == ADDR_W'(CMD_OFFSET) &&
                  $past(wr_data) == DATA_W'(3)));

  assert_forced_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && force_hit) |-> ((rd_data & DATA_W'(FORCE_MASK)) == DATA_W'(FORCE_MASK)));

  assert_oor_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && !in_range) |-> (rd_data == '0));

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> ($past(!in_range) && $past(rd_en || wr_en)));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(rd_data));

endmodule

// File: tb/sysctl_regfile_bench.sv
module sysctl_regfile_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        rst_req, shdn_req, acc_err;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  sysctl_regfile u_sysctl_regfile (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rst_req(rst_req), .shdn_req(shdn_req),
    .acc_err(acc_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // One write cycle; flags sampled in the cycle after the write.
  task automatic bus_write(input logic [11:0] a, input logic [31:0] d,
                           output logic r, output logic s, output logic e);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    r = rst_req; s = shdn_req; e = acc_err;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data; e = acc_err;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic e;
    check("R1 rd_data after reset", rd_data, 32'h0);
    check("R1 flags after reset", {29'd0, rst_req, shdn_req, acc_err}, 32'h0);
    bus_read(12'h100, d, e); check("R1/R6 word 0x40", d, 32'h35F2_0121);
    bus_read(12'h104, d, e); check("R1 word 0x41", d, 32'h0000_0002);
    bus_read(12'h108, d, e); check("R1/R6 word 0x42", d, 32'h35F3_0121);
    bus_read(12'h10C, d, e); check("R1/R6 word 0x43", d, 32'h35F4_0121);
    bus_read(12'h000, d, e); check("R1 word 0x00", d, 32'h0);
    bus_read(12'h7FC, d, e); check("R1 word 0x1FF", d, 32'h0);
    check("R8 no err in range", {31'd0, e}, 32'h0);
  endtask

  task automatic t_rw;
    logic [31:0] d; logic e, r, s;
    bus_write(12'h000, 32'hA5A5_5A5A, r, s, e);
    bus_write(12'h004, 32'hFFFF_FFFF, r, s, e);
    bus_write(12'h7FC, 32'h1234_5678, r, s, e);
    check("R8 no err on in-range write", {31'd0, e}, 32'h0);
    bus_read(12'h000, d, e); check("R5 word 0", d, 32'hA5A5_5A5A);
    bus_read(12'h004, d, e); check("R5 word 1", d, 32'hFFFF_FFFF);
    bus_read(12'h7FC, d, e); check("R5 last word", d, 32'h1234_5678);
    @(negedge clk);
    addr = 12'h004; wr_data = 32'h0BAD_F00D; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R5 same-cycle read old", rd_data, 32'hFFFF_FFFF);
    bus_read(12'h004, d, e); check("R5 then new", d, 32'h0BAD_F00D);
  endtask

  task automatic t_forced;
    logic [31:0] d; logic e, r, s;
    bus_write(12'h100, 32'h0, r, s, e);
    bus_read(12'h100, d, e); check("R6 forced on zero", d, 32'h3000_0000);
    bus_read(12'h101, d, e); check("R6 stored unchanged, unaligned unforced", d, 32'h0);
    bus_write(12'h104, 32'h0, r, s, e);
    bus_read(12'h104, d, e); check("R6 0x104 unforced", d, 32'h0);
    bus_write(12'h10C, 32'h8000_0001, r, s, e);
    bus_read(12'h10C, d, e); check("R6 0x10C forced", d, 32'hB000_0001);
  endtask

  task automatic t_cmd;
    logic [31:0] d; logic e, r, s;
    bus_write(12'h700, 32'hCAFE_0001, r, s, e);
    for (int v = 0; v <= 4; v++) begin
      bus_write(12'hF00, 32'(v), r, s, e);
      check($sformatf("R2 rst_req for %0d", v), {31'd0, r}, {31'd0, (v == 1 || v == 2)});
      check($sformatf("R3 shdn_req for %0d", v), {31'd0, s}, {31'd0, (v == 3)});
      check($sformatf("R4 no err for %0d", v), {31'd0, e}, 32'h0);
      @(negedge clk);
      check("R2/R3 pulse one cycle", {30'd0, rst_req, shdn_req}, 32'h0);
    end
    bus_read(12'h700, d, e); check("R4 storage untouched", d, 32'hCAFE_0001);
    bus_read(12'hF00, d, e); check("R7 cmd offset reads zero", d, 32'h0);
    check("R8 err on cmd read", {31'd0, e}, 32'h1);
  endtask

  task automatic t_oor;
    logic [31:0] d; logic e, r, s;
    bus_write(12'h800, 32'hDEAD_BEEF, r, s, e);
    check("R8 err on oor write", {31'd0, e}, 32'h1);
    check("R7 no req on oor write", {30'd0, r, s}, 32'h0);
    @(negedge clk);
    check("R8 err one cycle", {31'd0, acc_err}, 32'h0);
    bus_read(12'h000, d, e); check("R7 no alias", d, 32'hA5A5_5A5A);
    bus_read(12'h800, d, e); check("R7 oor read zero", d, 32'h0);
    check("R8 err on oor read", {31'd0, e}, 32'h1);
    bus_read(12'hFFC, d, e); check("R7 top read zero", d, 32'h0);
  endtask

  task automatic t_hold;
    logic [31:0] d; logic e;
    bus_read(12'h10C, d, e);
    @(negedge clk); addr = 12'h000;
    @(negedge clk); addr = 12'h800;
    @(negedge clk);
    check("R9 rd_data holds", rd_data, 32'hB000_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_rw;
    t_forced;
    t_cmd;
    t_oor;
    t_hold;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule